// File: doc/BRIEF.md
# AXI Write Issue Controller

This block sits between a cache-side write source and the write half of a 64-bit AXI master port. The source offers write requests (a line eviction, a single non-cacheable store, or a short burst), each with an address, a beat count, a one-bit transaction ID and an inner-attribute code. Once a request is accepted, the source streams that write's data beats on a separate valid/ready channel. The controller turns each accepted request into one AW transfer, with the attribute code placed on the AW user sideband. It forwards the data beats to the W channel strictly in acceptance order, marks the final beat of every write, and retires writes as B responses come back.

Two limits apply. At most four writes may be in flight at once, where in flight means accepted and not yet answered. At most three write addresses may be outstanding. A fourth write may therefore be accepted and send all of its data while its address is held back. That address is released in the cycle after a B response frees an address slot.

Top module: `axi_wr_issue`

## Requirements
- R1: Every accepted request produces exactly one AW transfer, and these transfers follow acceptance order. The fields are:
  - `m_awaddr`, `m_awid` and `m_awuser` are the request's address, ID and attribute code.
  - `m_awlen` is the request's beat count minus one. The request carries this value directly as `req_len`, zero-extended to 8 bits.
  - `m_awsize` is 3, meaning 8-byte beats.
  - `m_awburst` is 2'b01, meaning incrementing.
- R2: `req_ready` is high exactly when fewer than four writes are in flight. A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- R3: No AW transfer starts while three addresses are outstanding, that is, issued and not yet answered by B. An address waiting behind this cap keeps `m_awvalid` low.
- R4: W beats leave in acceptance order with data passed unchanged from the source. A source beat is taken (`src_wready` high) only when some accepted write still has data left to send.
- R5: `m_wlast` is high on beat number `req_len`+1 of each write and low on all its earlier beats.
- R6: Data beats are not gated by the AW channel. A write, including a fourth write whose address is held back, may send all of its beats before its AW transfer.
- R7: When an address is held back by the cap in R3, `m_awvalid` rises in the cycle after a B handshake frees an address slot.
- R8: `m_bready` is always high. Each B handshake retires one write and frees both one in-flight slot and one address slot. A returned `m_bid` always names an ID that has a write in flight.
- R9: Coming out of reset, `req_ready` is 1 while `m_awvalid` and `m_wvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Start address of the write |
| req_len | input | LEN_W | Beat count minus one |
| req_id | input | ID_W | Transaction ID |
| req_attr | input | ATTR_W | Inner memory attribute code |
| src_wvalid | input | 1 | Source data beat offered |
| src_wready | output | 1 | Source data beat taken |
| src_wdata | input | DATA_W | Source data beat |
| src_wstrb | input | DATA_W/8 | Source byte enables |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_awaddr | output | ADDR_W | AW address |
| m_awlen | output | 8 | AW burst length minus one |
| m_awsize | output | 3 | AW beat size code |
| m_awburst | output | 2 | AW burst type |
| m_awid | output | ID_W | AW ID |
| m_awuser | output | ATTR_W | Inner attributes sideband |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_wdata | output | DATA_W | W data |
| m_wstrb | output | DATA_W/8 | W byte enables |
| m_wlast | output | 1 | Final beat of a write |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready |
| m_bid | input | ID_W | B ID |

## Verification
Several properties are checked by the assertions on every cycle:
- the caps on in-flight writes and outstanding addresses;
- the rule that addresses outstanding never exceed writes in flight;
- AW and W holding steady while stalled;
- a returned B ID always matching an ID with a write in flight.

Some behaviours can only be shown by the bench's scenarios, which compare against a model. These are:
- the order and content of AW fields and data beats;
- the position of `m_wlast`;
- a fourth write sending its data while its address waits;
- the one-cycle release of that address after a B response.

// File: rtl/axi_wr_issue_pkg.sv
// Shared constants and helpers for the AXI write issue controller.
package axi_wr_issue_pkg;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // AXI size code for a beat of the given number of bytes (power of two assumed).
    function automatic logic [2:0] beat_size(input int unsigned bytes);
        return 3'($clog2(bytes));
    endfunction

endpackage

// File: rtl/axi_wr_txn_ring.sv
// Ring of accepted write transactions, shared by the AW and W paths.
// One write pointer fills entries on acceptance. Independent AW and W read
// pointers consume the same entries in acceptance order.
// Assumes DEPTH is a power of two, at least 2, and that the caller never
// pushes when DEPTH writes are in flight. An entry is reused only after both
// its address and its data have left.
module axi_wr_txn_ring #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 2,
    parameter int ID_W   = 1,
    parameter int ATTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [ID_W-1:0]   push_id,
    input  logic [ATTR_W-1:0] push_attr,
    input  logic              aw_pop,
    input  logic              w_pop,
    output logic              aw_pend,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic [ID_W-1:0]   aw_id,
    output logic [ATTR_W-1:0] aw_attr,
    output logic              w_pend,
    output logic [LEN_W-1:0]  w_len
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LEN_W-1:0]  len_q  [DEPTH];
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [ATTR_W-1:0] attr_q [DEPTH];
    logic [PW-1:0]     wr_ptr, aw_ptr, w_ptr;

    // Store the fields of a newly accepted request.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr[IW-1:0]] <= push_addr;
            len_q[wr_ptr[IW-1:0]]  <= push_len;
            id_q[wr_ptr[IW-1:0]]   <= push_id;
            attr_q[wr_ptr[IW-1:0]] <= push_attr;
        end
    end

    // Advance the fill, address and data pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            aw_ptr <= '0;
            w_ptr  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + PW'(1);
            if (aw_pop) aw_ptr <= aw_ptr + PW'(1);
            if (w_pop)  w_ptr  <= w_ptr + PW'(1);
        end
    end

    // Present the oldest entry still waiting on each channel.
    always_comb begin
        aw_pend = (aw_ptr != wr_ptr);
        w_pend  = (w_ptr != wr_ptr);
        aw_addr = addr_q[aw_ptr[IW-1:0]];
        aw_len  = len_q[aw_ptr[IW-1:0]];
        aw_id   = id_q[aw_ptr[IW-1:0]];
        aw_attr = attr_q[aw_ptr[IW-1:0]];
        w_len   = len_q[w_ptr[IW-1:0]];
    end

endmodule

// File: rtl/axi_wr_credits.sv
// Counters for writes in flight, addresses outstanding and writes per ID.
// Every B handshake retires one write and frees one address slot.
// Assumes the slave answers only IDs that have a write in flight.
// Limits are evaluated on registered counts, so a slot freed by B is seen
// in the following cycle.
module axi_wr_credits #(
    parameter int MAX_INFLIGHT = 4,
    parameter int MAX_AW       = 3,
    parameter int NUM_IDS      = 2,
    parameter int ID_W         = 1,
    parameter int CW           = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  txn_inc,
    input  logic [ID_W-1:0]       txn_id,
    input  logic                  aw_inc,
    input  logic                  b_fire,
    input  logic [ID_W-1:0]       b_id,
    output logic                  can_accept,
    output logic                  can_issue_aw,
    output logic [CW-1:0]         inflight,
    output logic [CW-1:0]         aw_out,
    output logic [NUM_IDS*CW-1:0] id_pend
);
    logic [CW-1:0] inflight_q, aw_out_q;

    // Track writes in flight and addresses outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
            aw_out_q   <= '0;
        end else begin
            inflight_q <= inflight_q + CW'(txn_inc) - CW'(b_fire);
            aw_out_q   <= aw_out_q + CW'(aw_inc) - CW'(b_fire);
        end
    end

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        logic [CW-1:0] cnt_q;
        logic          inc_i, dec_i;
        assign inc_i = txn_inc && (txn_id == ID_W'(i));
        assign dec_i = b_fire && (b_id == ID_W'(i));
        // Count writes in flight carrying this ID.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + CW'(inc_i) - CW'(dec_i);
        end
        assign id_pend[i*CW +: CW] = cnt_q;
    end

    assign inflight     = inflight_q;
    assign aw_out       = aw_out_q;
    assign can_accept   = (inflight_q < CW'(MAX_INFLIGHT));
    assign can_issue_aw = (aw_out_q < CW'(MAX_AW));

endmodule

// File: rtl/axi_wr_beat_ctr.sv
// Counts data beats within the write at the head of the W path and flags its
// last beat from the length recorded at acceptance.
// Assumes len is stable for the duration of one write.
module axi_wr_beat_ctr #(
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_fire,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] beat_q;

    assign last = (beat_q == len);

    // Step the beat index, wrapping to zero after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (w_fire) beat_q <= last ? '0 : beat_q + LEN_W'(1);
    end

endmodule

// File: rtl/axi_wr_issue.sv
// AXI write issue controller: accepts cache-side write requests and drives
// the AW, W and B channels of the master port.
// Caps writes in flight at MAX_INFLIGHT and outstanding addresses at MAX_AW.
// Sends data in acceptance order without waiting for addresses.
// Assumes the source holds offered data beats until taken, and that LEN_W <= 8.
module axi_wr_issue
    import axi_wr_issue_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 64,
    parameter int ID_W         = 1,
    parameter int NUM_IDS      = 2,
    parameter int ATTR_W       = 4,
    parameter int LEN_W        = 2,
    parameter int MAX_INFLIGHT = 4,
    parameter int MAX_AW       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [ID_W-1:0]     req_id,
    input  logic [ATTR_W-1:0]   req_attr,
    input  logic                src_wvalid,
    output logic                src_wready,
    input  logic [DATA_W-1:0]   src_wdata,
    input  logic [DATA_W/8-1:0] src_wstrb,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic [ID_W-1:0]     m_awid,
    output logic [ATTR_W-1:0]   m_awuser,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [ID_W-1:0]     m_bid
);
    localparam int STRB_W = DATA_W / 8;
    localparam int CW     = $clog2(MAX_INFLIGHT + 1);

    logic                  push, aw_fire, w_fire, w_pop, b_fire;
    logic                  aw_pend, w_pend, can_accept, can_issue_aw, last_beat;
    logic [LEN_W-1:0]      aw_len, w_len;
    logic [CW-1:0]         inflight, aw_out;
    logic [NUM_IDS*CW-1:0] id_pend;

    // Request side and handshake decode.
    assign req_ready = can_accept;
    assign push      = req_valid && req_ready;
    assign aw_fire   = m_awvalid && m_awready;
    assign w_fire    = m_wvalid && m_wready;
    assign w_pop     = w_fire && last_beat;
    assign m_bready  = 1'b1;
    assign b_fire    = m_bvalid && m_bready;

    axi_wr_txn_ring #(
        .DEPTH(MAX_INFLIGHT), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .ID_W(ID_W), .ATTR_W(ATTR_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(req_addr), .push_len(req_len),
        .push_id(req_id), .push_attr(req_attr),
        .aw_pop(aw_fire), .w_pop(w_pop),
        .aw_pend(aw_pend), .aw_addr(m_awaddr), .aw_len(aw_len),
        .aw_id(m_awid), .aw_attr(m_awuser),
        .w_pend(w_pend), .w_len(w_len)
    );

    axi_wr_credits #(
        .MAX_INFLIGHT(MAX_INFLIGHT), .MAX_AW(MAX_AW),
        .NUM_IDS(NUM_IDS), .ID_W(ID_W), .CW(CW)
    ) u_credits (
        .clk(clk), .rst_n(rst_n),
        .txn_inc(push), .txn_id(req_id), .aw_inc(aw_fire),
        .b_fire(b_fire), .b_id(m_bid),
        .can_accept(can_accept), .can_issue_aw(can_issue_aw),
        .inflight(inflight), .aw_out(aw_out), .id_pend(id_pend)
    );

    axi_wr_beat_ctr #(.LEN_W(LEN_W)) u_beats (
        .clk(clk), .rst_n(rst_n), .w_fire(w_fire), .len(w_len), .last(last_beat)
    );

    // AW channel: issue the next address only while an address slot is free.
    assign m_awvalid = aw_pend && can_issue_aw;
    assign m_awlen   = {{(8-LEN_W){1'b0}}, aw_len};
    assign m_awsize  = beat_size(STRB_W);
    assign m_awburst = BURST_INCR;

    // W channel: pass source beats through while an accepted write needs data.
    assign m_wvalid   = src_wvalid && w_pend;
    assign src_wready = m_wready && w_pend;
    assign m_wdata    = src_wdata;
    assign m_wstrb    = src_wstrb;
    assign m_wlast    = last_beat;

endmodule

// File: rtl/axi_wr_issue_chk.sv
// Assertion checker for axi_wr_issue, attached through bind below.
module axi_wr_issue_chk #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 64,
    parameter int ID_W         = 1,
    parameter int NUM_IDS      = 2,
    parameter int MAX_INFLIGHT = 4,
    parameter int MAX_AW       = 3,
    parameter int CW           = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  m_awvalid,
    input logic                  m_awready,
    input logic [ADDR_W-1:0]     m_awaddr,
    input logic                  m_wvalid,
    input logic                  m_wready,
    input logic [DATA_W-1:0]     m_wdata,
    input logic                  m_wlast,
    input logic                  m_bvalid,
    input logic [ID_W-1:0]       m_bid,
    input logic [CW-1:0]         inflight,
    input logic [CW-1:0]         aw_out,
    input logic [NUM_IDS*CW-1:0] id_pend
);
    AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(MAX_INFLIGHT)); // R2
    AST_AW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        aw_out <= CW'(MAX_AW)); // R3
    AST_AW_WITHIN_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        aw_out <= inflight); // R8
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R1
    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast)); // R4
    AST_B_KNOWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
        m_bvalid |-> (id_pend[m_bid*CW +: CW] != '0)); // R8

endmodule

bind axi_wr_issue axi_wr_issue_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .NUM_IDS(NUM_IDS),
    .MAX_INFLIGHT(MAX_INFLIGHT), .MAX_AW(MAX_AW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bid(m_bid),
    .inflight(inflight), .aw_out(aw_out), .id_pend(id_pend)
);

// File: tb/axi_wr_issue_tb.sv
module axi_wr_issue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_DIR      = 4;
    localparam int N_RAND     = 300;
    localparam int N_TOT      = N_DIR + N_RAND;
    localparam int LIMIT      = 100000;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_ready;
    logic [31:0] req_addr = 0;
    logic [1:0]  req_len = 0;
    logic        req_id = 0;
    logic [3:0]  req_attr = 0;
    logic        src_wvalid = 0, src_wready;
    logic [63:0] src_wdata = 0;
    logic [7:0]  src_wstrb = 8'hFF;
    logic        m_awvalid, m_awready = 0;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awid;
    logic [3:0]  m_awuser;
    logic        m_wvalid, m_wready = 0;
    logic [63:0] m_wdata;
    logic [7:0]  m_wstrb;
    logic        m_wlast;
    logic        m_bvalid = 0, m_bready;
    logic        m_bid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_wr_issue u_dut (.*);

    // Bench model state.
    logic [31:0] t_addr [N_TOT];
    logic [1:0]  t_len  [N_TOT];
    logic        t_id   [N_TOT];
    logic [3:0]  t_attr [N_TOT];
    bit aw_done [N_TOT];
    bit wl_done [N_TOT];
    bit b_done  [N_TOT];
    int n_req = 0, acc = 0, aw_idx = 0, w_txn = 0, w_beat = 0, bcnt = 0, aw_out_m = 0;
    int bsel = 0, b_budget = 0, cyc = 0;
    bit rand_mode = 0, probe_aw = 0;
    bit req_fire = 0, w_fire = 0;
    int checks = 0, failures = 0;

    function automatic logic [63:0] beat_data(input int t, input int b);
        return {8'hC3, 24'(t), 8'(b), 24'(t * 7 + b + 1)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Choose a B response that respects per-ID order; -1 when none is ready.
    function automatic int pick_b();
        int c1 = -1, c2 = -1;
        for (int k = 0; k < acc; k++)
            if (!b_done[k] && aw_done[k] && wl_done[k]) begin c1 = k; break; end
        if (c1 < 0) return -1;
        for (int k = 0; k < acc; k++)
            if (!b_done[k] && t_id[k] != t_id[c1]) begin c2 = k; break; end
        if (c2 >= 0 && aw_done[c2] && wl_done[c2] && ($urandom % 2 == 0)) return c2;
        return c1;
    endfunction

    // One clock: drive inputs after the falling edge, then evaluate handshakes.
    task automatic cycle();
        int c;
        @(negedge clk);
        cyc++;
        if (req_fire) req_valid = 0;
        if (w_fire) src_wvalid = 0;
        req_fire = 0;
        w_fire = 0;
        if (!req_valid && acc < n_req && (!rand_mode || $urandom % 4 != 0)) begin
            req_valid = 1;
            req_addr = t_addr[acc];
            req_len = t_len[acc];
            req_id = t_id[acc];
            req_attr = t_attr[acc];
        end
        if (!src_wvalid && w_txn < acc && (!rand_mode || $urandom % 5 != 0)) begin
            src_wvalid = 1;
            src_wdata = beat_data(w_txn, w_beat);
        end
        m_awready = rand_mode ? ($urandom % 10 < 7) : 1'b1;
        m_wready = rand_mode ? ($urandom % 10 < 7) : 1'b1;
        m_bvalid = 0;
        if (b_budget != 0 && (!rand_mode || $urandom % 10 < 6)) begin
            c = pick_b();
            if (c >= 0) begin
                m_bvalid = 1;
                m_bid = t_id[c];
                bsel = c;
                if (b_budget > 0) b_budget--;
            end
        end
        #1;
        check(req_ready == ((acc - bcnt) < 4), "R2 req_ready", 64'(req_ready), 64'((acc - bcnt) < 4));
        if (probe_aw) begin
            check(m_awvalid == 1'b1, "R7 held address released", 64'(m_awvalid), 64'd1);
            probe_aw = 0;
        end
        if (req_valid && req_ready) begin
            req_fire = 1;
            acc++;
        end
        if (m_awvalid && m_awready) begin
            check(aw_out_m < 3, "R3 address cap", 64'(aw_out_m), 64'd2);
            check(m_awaddr == t_addr[aw_idx], "R1 awaddr", 64'(m_awaddr), 64'(t_addr[aw_idx]));
            check(m_awlen == 8'(t_len[aw_idx]), "R1 awlen", 64'(m_awlen), 64'(t_len[aw_idx]));
            check(m_awid == t_id[aw_idx] && m_awuser == t_attr[aw_idx], "R1 awid/awuser",
                  64'({m_awid, m_awuser}), 64'({t_id[aw_idx], t_attr[aw_idx]}));
            check(m_awsize == 3'd3 && m_awburst == 2'b01, "R1 size/burst",
                  64'({m_awsize, m_awburst}), 64'({3'd3, 2'b01}));
            aw_done[aw_idx] = 1;
            aw_idx++;
            aw_out_m++;
        end
        if (m_wvalid && m_wready) begin
            w_fire = 1;
            check(src_wready == 1'b1, "R4 source beat taken", 64'(src_wready), 64'd1);
            check(m_wdata == beat_data(w_txn, w_beat), "R4 wdata order", m_wdata, beat_data(w_txn, w_beat));
            check(m_wlast == (w_beat == int'(t_len[w_txn])), "R5 wlast", 64'(m_wlast),
                  64'(w_beat == int'(t_len[w_txn])));
            if (w_beat == int'(t_len[w_txn])) begin
                wl_done[w_txn] = 1;
                w_txn++;
                w_beat = 0;
            end else begin
                w_beat++;
            end
        end
        if (m_bvalid) begin
            check(m_bready == 1'b1, "R8 bready", 64'(m_bready), 64'd1);
            b_done[bsel] = 1;
            bcnt++;
            aw_out_m--;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < N_DIR; k++) begin
            t_addr[k] = 32'h1000 + 32'(k * 32);
            t_len[k] = 2'd0;
            t_id[k] = k[0];
            t_attr[k] = 4'(k + 1);
        end
        for (int k = N_DIR; k < N_TOT; k++) begin
            t_addr[k] = {$urandom() >> 5, 5'b0};
            t_len[k] = 2'($urandom % 4);
            t_id[k] = 1'($urandom % 2);
            t_attr[k] = 4'($urandom % 16);
        end
        t_len[N_DIR] = 2'd3;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R9 reset req_ready", 64'(req_ready), 64'd1);
        check(m_awvalid == 1'b0, "R9 reset awvalid", 64'(m_awvalid), 64'd0);
        check(m_wvalid == 1'b0, "R9 reset wvalid", 64'(m_wvalid), 64'd0);

        // Directed: four single-beat writes, no B responses allowed.
        n_req = N_DIR;
        b_budget = 0;
        repeat (12) cycle();
        check(aw_idx == 3, "R3 only three addresses issued", 64'(aw_idx), 64'd3);
        check(w_txn == 4, "R6 fourth write data sent before its address", 64'(w_txn), 64'd4);
        check(req_ready == 1'b0, "R2 ready low with four in flight", 64'(req_ready), 64'd0);
        check(m_awvalid == 1'b0, "R3 fourth address held", 64'(m_awvalid), 64'd0);
        b_budget = 1;
        while (bcnt < 1 && cyc < LIMIT) cycle();
        probe_aw = 1;
        cycle();
        b_budget = -1;
        while (bcnt < n_req && cyc < LIMIT) cycle();
        check(aw_idx == N_DIR, "R1 directed addresses all issued", 64'(aw_idx), 64'(N_DIR));

        // Random phase.
        rand_mode = 1;
        n_req = N_TOT;
        while (bcnt < n_req && cyc < LIMIT) cycle();
        if (cyc >= LIMIT) begin
            failures++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", bcnt, n_req);
        end
        check(bcnt == N_TOT, "R8 all writes retired", 64'(bcnt), 64'(N_TOT));
        check(w_txn == N_TOT, "R4 all data sent", 64'(w_txn), 64'(N_TOT));
        check(aw_idx == N_TOT, "R1 all addresses sent", 64'(aw_idx), 64'(N_TOT));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule